// File: doc/BRIEF.md
# Late-Write Synchronous Static Memory

This block is a single-port synchronous static memory. Its data bus is split into an input, an output and an output-drive qualifier, so a pad ring can join them into one shared bus. Command, address and byte-lane enables are captured on the rising clock edge. A read places its word on the output from the falling edge of the same cycle, half a cycle after capture, and holds it until the next falling edge. A write is late: its data arrives on the rising edge one full cycle after its command.

Late data goes into a one-entry write buffer. That entry is moved into the storage array when another write pushes it out. A read compares its address with the buffered entry and lays the enabled buffered lanes over the array word, so a read always sees the newest data, even in the cycle straight after the write.

Output drive is gated with no clock involved by an output-enable input and by a sleep input. Sleep also blocks new commands and leaves the stored data alone. One parameter selects a wide organisation (four 9-bit lanes) or a narrow one (two 9-bit lanes with twice the words). A second parameter sets the depth.

Top module: `lwsram_core`

## Requirements
- R1: A read command (sel=1, we=0, sleep=0 at a rising edge) makes rdata_oe rise at the falling edge of that cycle, with rdata holding the read word, and rdata_oe does not change at the rising edges.
- R2: For a write command (sel=1, we=1, sleep=0) captured at one rising edge, wdata is taken at the next rising edge.
- R3: Lane i of a word is bits [9i+8:9i]. A write changes lane i only when byte_we[i] was 1 with its command. Lanes with byte_we[i]=0 keep their old value.
- R4: A read returns the newest written value of every lane at its address, including a write still in the buffer and a write issued in the cycle just before the read.
- R5: Consecutive write commands to different or equal addresses all reach storage, each with its own late data.
- R6: A cycle with sel=0 at a rising edge makes rdata_oe low from the following falling edge.
- R7: While oe is 0, rdata_oe is 0 at once, without waiting for a clock edge. Raising oe again brings back the pending read output.
- R8: While sleep is 1, rdata_oe is 0 and commands at rising edges are ignored. Stored contents survive sleep.
- R9: After synchronous active-high reset, rdata_oe is 0 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands on rising edge, read output on falling edge |
| rst | input | 1 | Synchronous active-high reset of control state |
| sel | input | 1 | Chip select; 0 is a deselect cycle |
| we | input | 1 | 1 = write command, 0 = read command |
| addr | input | AW | Word address (10 bits wide, 11 bits narrow by default) |
| byte_we | input | LANES | Per-lane write enables, captured with the command |
| wdata | input | DW | Late write data, one cycle after its command |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down; blocks commands and output drive |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | Output drive qualifier for rdata |

## Verification
The properties assume that reset is held for at least one rising edge before any command. They also assume that the write data for a captured write is driven in the following cycle and never left floating. In addition, oe and sleep must change only away from the clock edges. The bench meets these conditions: it drives every input one time step after the rising edge, always supplies data for the pending write even when the next cycle sleeps, and toggles oe inside a cycle only in the directed check of asynchronous behaviour. Random addresses are mostly kept to sixteen words, so that buffer hits, same-address write pairs and reads right after writes happen often.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    localparam int LANE_W   = 9;
    localparam int MAX_LN   = 4;
    localparam int MAX_DW   = LANE_W * MAX_LN;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic sel, input logic we, input logic slp);
        if (!sel || slp) return OP_NOP;
        return we ? OP_WR : OP_RD;
    endfunction

    function automatic int lanes_of(input bit wide);
        return wide ? 4 : 2;
    endfunction

    // Overlay the enabled lanes of upd onto base.
    function automatic logic [MAX_DW-1:0] lane_merge(input logic [MAX_DW-1:0] base,
                                                     input logic [MAX_DW-1:0] upd,
                                                     input logic [MAX_LN-1:0] en);
        logic [MAX_DW-1:0] r;
        r = base;
        for (int l = 0; l < MAX_LN; l++)
            if (en[l]) r[l*LANE_W +: LANE_W] = upd[l*LANE_W +: LANE_W];
        return r;
    endfunction

endpackage

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int AW    = 10,
    parameter int DW    = 36,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_lane,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);
    import lwsram_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++)
                if (wr_lane[l])
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf #(
    parameter int AW    = 10,
    parameter int DW    = 36,
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lwsram_pkg::op_e      op,
    input  logic [AW-1:0]        addr,
    input  logic [LANES-1:0]     byte_we,
    input  logic [DW-1:0]        wdata,
    output logic                 commit_en,
    output logic [AW-1:0]        commit_addr,
    output logic [LANES-1:0]     commit_be,
    output logic [DW-1:0]        commit_data,
    input  logic [AW-1:0]        look_addr,
    input  logic [DW-1:0]        array_word,
    output logic [DW-1:0]        merged_word
);
    import lwsram_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
    } due_t;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    data;
    } entry_t;

    due_t   due_q;
    entry_t ent_q;

    // Stage 1 holds a captured write until its data arrives; stage 2 is the buffer.
    always_ff @(posedge clk) begin
        if (rst) begin
            due_q.vld <= 1'b0;
            ent_q.vld <= 1'b0;
        end else begin
            due_q.vld <= (op == OP_WR);
            if (op == OP_WR) begin
                due_q.addr <= addr;
                due_q.be   <= byte_we;
            end
            if (due_q.vld) begin
                ent_q.vld  <= 1'b1;
                ent_q.addr <= due_q.addr;
                ent_q.be   <= due_q.be;
                ent_q.data <= wdata;
            end
        end
    end

    // The old entry drains into the array in the edge that replaces it.
    assign commit_en   = due_q.vld && ent_q.vld;
    assign commit_addr = ent_q.addr;
    assign commit_be   = ent_q.be;
    assign commit_data = ent_q.data;

    logic              hit;
    logic [MAX_DW-1:0] mix;

    always_comb begin
        hit = ent_q.vld && (ent_q.addr == look_addr);
        mix = lane_merge(MAX_DW'(array_word), MAX_DW'(ent_q.data), MAX_LN'(ent_q.be));
        merged_word = hit ? mix[DW-1:0] : array_word;
    end

endmodule

// File: rtl/lwsram_rdport.sv
module lwsram_rdport #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic            clk,
    input  logic            rst,
    input  lwsram_pkg::op_e op,
    input  logic [AW-1:0]   addr,
    input  logic            oe,
    input  logic            sleep,
    output logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   word_in,
    output logic [DW-1:0]   rdata,
    output logic            rdata_oe
);
    import lwsram_pkg::*;

    logic          rd_vld_q;
    logic          out_en_q;
    logic [DW-1:0] out_q;

    // Rising edge: register the read.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q <= 1'b0;
        end else begin
            rd_vld_q <= (op == OP_RD);
        end
        rd_addr <= addr;
    end

    // Falling edge: latch the word and the drive state for a full cycle.
    always_ff @(negedge clk) begin
        if (rst) begin
            out_en_q <= 1'b0;
        end else begin
            out_en_q <= rd_vld_q;
            if (rd_vld_q) out_q <= word_in;
        end
    end

    assign rdata    = out_q;
    assign rdata_oe = out_en_q && oe && !sleep;

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core #(
    parameter bit  WIDE    = 1'b1,
    parameter int  BASE_AW = 10,
    localparam int LANES   = lwsram_pkg::lanes_of(WIDE),
    localparam int DW      = LANES * lwsram_pkg::LANE_W,
    localparam int AW      = WIDE ? BASE_AW : BASE_AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] byte_we,
    input  logic [DW-1:0]    wdata,
    input  logic             oe,
    input  logic             sleep,
    output logic [DW-1:0]    rdata,
    output logic             rdata_oe
);
    import lwsram_pkg::*;

    op_e              op;
    logic             commit_en;
    logic [AW-1:0]    commit_addr;
    logic [LANES-1:0] commit_be;
    logic [DW-1:0]    commit_data;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    array_word;
    logic [DW-1:0]    merged_word;

    assign op = decode_op(sel, we, sleep);

    lwsram_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (commit_addr),
        .wr_lane (commit_be),
        .wr_data (commit_data),
        .rd_addr (rd_addr),
        .rd_data (array_word)
    );

    lwsram_wbuf #(.AW(AW), .DW(DW), .LANES(LANES)) u_wbuf (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .addr        (addr),
        .byte_we     (byte_we),
        .wdata       (wdata),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_be   (commit_be),
        .commit_data (commit_data),
        .look_addr   (rd_addr),
        .array_word  (array_word),
        .merged_word (merged_word)
    );

    lwsram_rdport #(.AW(AW), .DW(DW)) u_rdport (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .addr     (addr),
        .oe       (oe),
        .sleep    (sleep),
        .rd_addr  (rd_addr),
        .word_in  (merged_word),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
    parameter bit  WIDE    = 1'b1,
    parameter int  BASE_AW = 10,
    localparam int LANES   = lwsram_pkg::lanes_of(WIDE),
    localparam int DW      = LANES * lwsram_pkg::LANE_W,
    localparam int AW      = WIDE ? BASE_AW : BASE_AW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             we,
    input logic [AW-1:0]    addr,
    input logic [LANES-1:0] byte_we,
    input logic [DW-1:0]    wdata,
    input logic             oe,
    input logic             sleep,
    input logic [DW-1:0]    rdata,
    input logic             rdata_oe
);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !rdata_oe);

    // R8
    sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rdata_oe);

    // R6
    deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sel && !we && !sleep)) |-> !rdata_oe);

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel && !we && !sleep) && oe && !sleep) |-> rdata_oe);

    // R4
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(sel && we && !sleep, 2)
         && $past(sel && !we && !sleep) && ($past(addr) == $past(addr, 2))
         && (&$past(byte_we, 2))) |-> (rdata == $past(wdata)));

endmodule

bind lwsram_core lwsram_chk #(.WIDE(WIDE), .BASE_AW(BASE_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .we       (we),
    .addr     (addr),
    .byte_we  (byte_we),
    .wdata    (wdata),
    .oe       (oe),
    .sleep    (sleep),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/lwsram_core_tb.sv
`timescale 1ns/100ps
module lwsram_core_tb;
    localparam int AW    = 10;
    localparam int LN    = 4;
    localparam int DW    = 36;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0, we = 1'b0, oe = 1'b1, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] byte_we = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    lwsram_core u_dut (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .byte_we(byte_we),
        .wdata(wdata), .oe(oe), .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #5 clk = ~clk;

    logic [DW-1:0] ref_mem [DEPTH];
    int            n_chk = 0, n_bad = 0;

    bit            pend_wr = 0;
    logic [AW-1:0] pend_addr = '0;
    logic [LN-1:0] pend_be = '0;
    bit            prev_rd = 0;
    logic [DW-1:0] prev_exp = '0;
    string         prev_tag = "R4";
    logic          last_oe = 1'b0;
    string         phase_tag = "";

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] lanes_over(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LN-1:0] en);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < LN; l++)
            if (en[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t = {$urandom, $urandom};
        return t[DW-1:0];
    endfunction

    // One command per cycle: drive at rise+1, check previous read at rise+7.
    task automatic step(input bit s, input bit w, input logic [AW-1:0] a,
                        input logic [LN-1:0] b, input bit o, input bit slp);
        bit            cur_rd, hit_prev;
        logic [DW-1:0] wd;
        logic          exp_oe;
        string         t;
        @(posedge clk);
        #1;
        // R1: drive state holds across the rising edge
        chk(rdata_oe === last_oe, "R1", DW'(rdata_oe), DW'(last_oe));
        hit_prev = pend_wr && (pend_addr == a);
        wd = rnd_word();
        wdata = wd;
        if (pend_wr) ref_mem[pend_addr] = lanes_over(ref_mem[pend_addr], wd, pend_be);
        sel = s; we = w; addr = a; byte_we = b; oe = o; sleep = slp;
        cur_rd = s && !w && !slp;
        #6;
        exp_oe = prev_rd && oe && !sleep;
        if (prev_rd) t = sleep ? "R8" : (!oe ? "R7" : "R1");
        else t = "R6";
        chk(rdata_oe === exp_oe, t, DW'(rdata_oe), DW'(exp_oe));
        if (exp_oe) chk(rdata === prev_exp, prev_tag, rdata, prev_exp);
        last_oe = rdata_oe;
        prev_rd = cur_rd;
        prev_exp = ref_mem[a];
        prev_tag = (phase_tag != "") ? phase_tag : (hit_prev ? "R4" : "R3");
        pend_wr = s && w && !slp;
        pend_addr = a;
        pend_be = b;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1a7e));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #6;
        // R9: quiet after reset
        chk(rdata_oe === 1'b0, "R9", DW'(rdata_oe), '0);

        // R2: fill every word with full-lane writes, data one cycle late
        phase_tag = "R2";
        for (int i = 0; i < DEPTH; i++) step(1, 1, AW'(i), '1, 1, 0);
        step(1, 0, 10'd5, '0, 1, 0);
        step(1, 0, 10'd1023, '0, 1, 0);

        // R5: back-to-back writes, including a repeat of one address
        phase_tag = "R5";
        step(1, 1, 10'd20, '1, 1, 0);
        step(1, 1, 10'd21, '1, 1, 0);
        step(1, 1, 10'd20, 4'b0101, 1, 0);
        step(1, 1, 10'd22, '1, 1, 0);
        step(1, 0, 10'd20, '0, 1, 0);
        step(1, 0, 10'd21, '0, 1, 0);
        step(1, 0, 10'd22, '0, 1, 0);

        // R4: write then read same word next cycle; read, write, read
        phase_tag = "R4";
        step(1, 1, 10'd30, '1, 1, 0);
        step(1, 0, 10'd30, '0, 1, 0);
        step(1, 0, 10'd31, '0, 1, 0);
        step(1, 1, 10'd31, 4'b0010, 1, 0);
        step(1, 0, 10'd31, '0, 1, 0);

        // R3: single-lane writes leave the other lanes alone
        phase_tag = "R3";
        for (int l = 0; l < LN; l++) step(1, 1, 10'd40, LN'(1 << l), 1, 0);
        step(0, 0, 10'd0, '0, 1, 0);
        step(1, 0, 10'd40, '0, 1, 0);
        step(1, 1, 10'd41, 4'b0000, 1, 0);
        step(1, 0, 10'd41, '0, 1, 0);

        // R6: deselect after a read turns the drive off
        phase_tag = "R6";
        step(1, 0, 10'd7, '0, 1, 0);
        step(0, 0, 10'd7, '0, 1, 0);
        step(0, 1, 10'd7, '1, 1, 0);

        // R7: oe acts inside a cycle
        phase_tag = "R7";
        step(1, 0, 10'd9, '0, 1, 0);
        step(1, 0, 10'd9, '0, 1, 0);
        #0.5 oe = 1'b0;
        #0.5 chk(rdata_oe === 1'b0, "R7", DW'(rdata_oe), '0);
        oe = 1'b1;
        #0.5 chk(rdata_oe === 1'b1, "R7", DW'(rdata_oe), DW'(1));

        // R8: sleep blocks commands and keeps contents
        phase_tag = "R8";
        step(1, 1, 10'd50, '1, 1, 0);
        step(1, 0, 10'd50, '0, 1, 1);
        step(1, 1, 10'd50, '1, 1, 1);
        step(1, 0, 10'd50, '0, 1, 1);
        step(1, 0, 10'd50, '0, 1, 0);
        step(1, 0, 10'd51, '0, 1, 0);

        // Random mix over a small window to force buffer hits
        phase_tag = "";
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] a;
            a = ($urandom_range(0, 7) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
            step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, a,
                 LN'($urandom), $urandom_range(0, 9) != 0, $urandom_range(0, 19) == 0);
        end
        step(0, 0, '0, '0, 1, 0);
        step(0, 0, '0, '0, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule